// File: doc/BRIEF.md
# Single/Double to Extended Float Widener

This block takes a floating-point memory image in one of three encodings and turns it into the 80-bit extended encoding. The extended form has a sign, a 15-bit exponent biased by 16383, and a 64-bit significand whose top bit is an explicit integer bit. A 2-bit format code on the input selects how the lower bits of the input word are read: as a 32-bit single, as a 64-bit double, or as an 80-bit extended value. An extended value is passed through without change.

The conversion is exact, so no rounding is involved. Normal numbers are rebiased, and their fractions are left-aligned under a set integer bit. A subnormal single or double is normalised with a leading-zero count into the wider exponent range, and a denormal-operand flag is raised for it. Zeros keep their sign. Infinities and NaNs get the all-ones exponent. The result is registered once, under an input enable, so a load path can place it directly into a register-stack slot.

Top module: `fpw_widen`

## Requirements
- R1: While reset is asserted and after it is released, `out_vld`, `out_denorm` and all of `out_bits` are 0 until the first enabled input.
- R2: Format codes 2 and 3 (extended) copy `in_bits[79:0]` unchanged to `out_bits`. `out_denorm` is 1 exactly when the exponent field `in_bits[78:64]` is 0 and `in_bits[63:0]` is nonzero.
- R3: Format code 0 reads a single from `in_bits[31:0]`: sign at bit 31, 8-bit exponent at bits 30:23, 23-bit fraction at bits 22:0. A normal single gives exponent e+16256 and significand {1, fraction, 40 zeros}.
- R4: Format code 1 reads a double from `in_bits[63:0]`: sign at bit 63, 11-bit exponent at bits 62:52, 52-bit fraction at bits 51:0. A normal double gives exponent e+15360 and significand {1, fraction, 11 zeros}.
- R5: A single or double with a zero exponent and a nonzero fraction sets `out_denorm`. Its significand is shifted left until bit 63 is 1, and the exponent is (1+16256) or (1+15360) minus the shift amount counted from the aligned position.
- R6: A single or double zero of either sign gives the same sign with exponent 0 and significand 0, and does not set `out_denorm`.
- R7: A single or double with an all-ones exponent gives exponent 0x7FFF. The significand is {1, fraction left-aligned, zeros}, so infinity gives 0x8000_0000_0000_0000 and a NaN keeps its payload.
- R8: Output bits are `out_bits[79]` for the sign, `[78:64]` for the exponent and `[63:0]` for the significand. The result and `out_vld` appear one clock after the cycle in which `in_en` is 1.
- R9: A cycle with `in_en` at 0 leaves `out_bits` and `out_denorm` unchanged and drives `out_vld` to 0 in the next cycle.
- R10: The single image 0x3F99999A (the rounded form of 1.2) widens exactly to 0x3FFF_99999A00_00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_en | input | 1 | Capture enable for the conversion |
| in_fmt | input | 2 | 0 single, 1 double, 2 or 3 extended |
| in_bits | input | 80 | Source image, right-aligned |
| out_vld | output | 1 | Result was captured last cycle |
| out_bits | output | 80 | Extended result |
| out_denorm | output | 1 | Source was a denormal operand |

## Verification
The assertions assume that `in_fmt` and `in_bits` are known whenever `in_en` is 1. They also assume that the unused upper bits of a single or double image carry no meaning, so those bits may hold anything. The bench drives random bits in those upper positions on purpose. It biases the exponent field towards zero and towards all ones, so that the subnormal and special-value branches are reached often. It also interleaves cycles with the enable low, so that the hold behaviour is checked against arbitrary input values.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  localparam int EXT_W   = 80;
  localparam int MANT_W  = 64;
  localparam int XEXP_W  = 15;
  localparam int XBIAS   = 16383;
  localparam int SGL_EW  = 8;
  localparam int SGL_FW  = 23;
  localparam int DBL_EW  = 11;
  localparam int DBL_FW  = 52;

  typedef enum logic [1:0] {
    FMT_SGL  = 2'd0,
    FMT_DBL  = 2'd1,
    FMT_EXT  = 2'd2,
    FMT_EXT2 = 2'd3
  } fmt_e;

  typedef struct packed {
    logic              sign;
    logic [XEXP_W-1:0] exp;
    logic [MANT_W-1:0] mant;
  } xval_t;
endpackage

// File: rtl/fpw_lzc.sv
module fpw_lzc #(
  parameter int W  = 64,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpw_narrow.sv
module fpw_narrow
  import fpw_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23,
  localparam int BIAS_IN = (1 << (EW - 1)) - 1,
  localparam int ADJ     = XBIAS - BIAS_IN,
  localparam int PADW    = MANT_W - 1 - FW,
  localparam int CW      = $clog2(MANT_W) + 1
) (
  input  logic [EW+FW:0] src,
  output xval_t          res,
  output logic           denorm
);
  logic [EW-1:0]     e_in;
  logic [FW-1:0]     f_in;
  logic [MANT_W-1:0] aligned;
  logic [CW-1:0]     lz;

  assign e_in    = src[EW+FW-1:FW];
  assign f_in    = src[FW-1:0];
  assign aligned = {1'b0, f_in, {PADW{1'b0}}};

  fpw_lzc #(.W(MANT_W)) u_lzc (.vec(aligned), .cnt(lz));

  always_comb begin
    res.sign = src[EW+FW];
    res.exp  = '0;
    res.mant = '0;
    denorm   = 1'b0;
    if (e_in == '1) begin
      res.exp  = '1;
      res.mant = {1'b1, f_in, {PADW{1'b0}}};
    end else if (e_in != '0) begin
      res.exp  = XEXP_W'(32'(e_in) + 32'(ADJ));
      res.mant = {1'b1, f_in, {PADW{1'b0}}};
    end else if (f_in != '0) begin
      denorm   = 1'b1;
      res.exp  = XEXP_W'(32'(1 + ADJ) - 32'(lz));
      res.mant = aligned << lz;
    end
  end
endmodule

// File: rtl/fpw_widen.sv
module fpw_widen
  import fpw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_en,
  input  logic [1:0]       in_fmt,
  input  logic [EXT_W-1:0] in_bits,
  output logic             out_vld,
  output logic [EXT_W-1:0] out_bits,
  output logic             out_denorm
);
  xval_t sgl_res, dbl_res, nxt_val;
  logic  sgl_dn, dbl_dn, nxt_dn;
  fmt_e  fmt;

  assign fmt = fmt_e'(in_fmt);

  fpw_narrow #(.EW(SGL_EW), .FW(SGL_FW)) u_sgl (
    .src(in_bits[SGL_EW+SGL_FW:0]), .res(sgl_res), .denorm(sgl_dn));
  fpw_narrow #(.EW(DBL_EW), .FW(DBL_FW)) u_dbl (
    .src(in_bits[DBL_EW+DBL_FW:0]), .res(dbl_res), .denorm(dbl_dn));

  always_comb begin
    case (fmt)
      FMT_SGL: begin nxt_val = sgl_res; nxt_dn = sgl_dn; end
      FMT_DBL: begin nxt_val = dbl_res; nxt_dn = dbl_dn; end
      default: begin
        nxt_val = xval_t'(in_bits);
        nxt_dn  = (in_bits[78:64] == '0) && (in_bits[63:0] != '0);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld    <= 1'b0;
      out_bits   <= '0;
      out_denorm <= 1'b0;
    end else begin
      out_vld <= in_en;
      if (in_en) begin
        out_bits   <= nxt_val;
        out_denorm <= nxt_dn;
      end
    end
  end

  a_r2_ext_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(in_fmt[1])) |-> (out_bits == $past(in_bits)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_en) |-> ($stable(out_bits) && $stable(out_denorm)));
  a_r5_int_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !$past(in_fmt[1]) && out_bits[78:64] != '0) |-> out_bits[63]);
  a_r5_flag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_denorm |-> (out_bits[63:0] != '0));
  a_r6_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !$past(in_fmt[1]) && out_bits[78:64] == '0) |-> (out_bits[63:0] == '0 && !out_denorm));
endmodule

// File: tb/fpw_widen_test.sv
module fpw_widen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, in_en;
  logic [1:0]  in_fmt;
  logic [79:0] in_bits;
  logic        out_vld, out_denorm;
  logic [79:0] out_bits;
  int n_chk, n_bad;
  bit done;

  fpw_widen uut (.clk(clk), .rst_n(rst_n), .in_en(in_en), .in_fmt(in_fmt),
    .in_bits(in_bits), .out_vld(out_vld), .out_bits(out_bits), .out_denorm(out_denorm));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [80:0] ref_widen(input logic [1:0] f, input logic [79:0] s);
    logic sg; int ew, fw, e, adj; logic [63:0] fr, m; logic [14:0] xe; logic dn;
    if (f[1]) return {(s[78:64] == 0 && s[63:0] != 0), s};
    if (f == 2'd0) begin ew = 8; fw = 23; sg = s[31]; e = int'(s[30:23]); fr = 64'(s[22:0]); end
    else begin ew = 11; fw = 52; sg = s[63]; e = int'(s[62:52]); fr = 64'(s[51:0]); end
    adj = 16383 - ((1 << (ew - 1)) - 1);
    dn = 1'b0; xe = '0; m = '0;
    if (e == (1 << ew) - 1) begin xe = 15'h7FFF; m = (64'd1 << 63) | (fr << (63 - fw)); end
    else if (e != 0) begin xe = 15'(e + adj); m = (64'd1 << 63) | (fr << (63 - fw)); end
    else if (fr != 0) begin
      dn = 1'b1; m = fr << (63 - fw); e = 1 + adj;
      for (int k = 0; k < 64; k++) if (!m[63]) begin m = m << 1; e = e - 1; end
      xe = 15'(e);
    end
    return {dn, sg, xe, m};
  endfunction

  task automatic check(input string req, input logic [80:0] act, input logic [80:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic conv(input string req, input logic [1:0] f, input logic [79:0] s);
    logic [80:0] e;
    e = ref_widen(f, s);
    @(negedge clk); in_en = 1'b1; in_fmt = f; in_bits = s;
    @(negedge clk); in_en = 1'b0;
    check(req, {out_denorm, out_bits}, e);
    check({req, " R8 valid"}, 81'(out_vld), 81'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [80:0] held;
    n_chk = 0; n_bad = 0;
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_en = 1'b0; in_fmt = '0; in_bits = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", {out_vld, out_denorm, out_bits}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {out_vld, out_denorm, out_bits}, '0);

    conv("R10 single 1.2", 2'd0, 80'h3F99999A);
    check("R10 literal", {out_denorm, out_bits}, {1'b0, 80'h3FFF_99999A00_00000000});
    conv("R3 single 1.0", 2'd0, 80'h3F800000);
    check("R3 literal", 81'(out_bits), 81'h3FFF_8000000000000000);
    conv("R4 double -2.0", 2'd1, 80'hC000000000000000);
    check("R4 literal", 81'(out_bits), 81'hC000_8000000000000000);
    conv("R5 single min sub", 2'd0, 80'h00000001);
    check("R5 literal", {out_denorm, out_bits}, {1'b1, 80'h3F6A_8000000000000000});
    conv("R5 single max sub", 2'd0, 80'h807FFFFF);
    conv("R5 double min sub", 2'd1, 80'h1);
    check("R5 dbl literal", {out_denorm, out_bits}, {1'b1, 80'h3BCD_8000000000000000});
    conv("R5 double max sub", 2'd1, 80'h000FFFFFFFFFFFFF);
    conv("R6 single -0", 2'd0, 80'hFFFF_0000_0000_8000_0000);
    check("R6 literal", {out_denorm, out_bits}, {1'b0, 80'h8000_0000000000000000});
    conv("R6 double +0", 2'd1, 80'h0);
    conv("R7 single +inf", 2'd0, 80'h7F800000);
    check("R7 literal", 81'(out_bits), 81'h7FFF_8000000000000000);
    conv("R7 double nan", 2'd1, 80'hFFF8000000000001);
    conv("R2 ext copy", 2'd2, 80'h1234_56789ABCDEF01234);
    conv("R2 ext denorm", 2'd3, 80'h8000_0000000000000005);
    check("R2 literal", 81'(out_denorm), 81'd1);

    held = {out_denorm, out_bits};
    @(negedge clk); in_en = 1'b0; in_fmt = 2'd0; in_bits = 80'h3F800000;
    @(negedge clk);
    check("R9 hold", {out_denorm, out_bits}, held);
    check("R9 valid low", 81'(out_vld), 81'd0);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] f; logic [79:0] s; int sel;
      f = 2'($urandom);
      s = {16'($urandom), $urandom, $urandom};
      sel = int'($urandom % 4);
      if (f == 2'd0 && sel == 0) s[30:23] = '0;
      if (f == 2'd0 && sel == 1) s[30:23] = '1;
      if (f == 2'd1 && sel == 0) s[62:52] = '0;
      if (f == 2'd1 && sel == 1) s[62:52] = '1;
      if (f[1] && sel == 0) s[78:64] = '0;
      conv("R2-random", f, s);
      if ($urandom % 5 == 0) begin
        held = {out_denorm, out_bits};
        @(negedge clk); in_fmt = 2'($urandom); in_bits = {16'($urandom), $urandom, $urandom};
        @(negedge clk);
        check("R9 random hold", {out_denorm, out_bits}, held);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule